// File: doc/BRIEF.md
# Word Address Transformation Stage

This block sits between a requester and a downstream memory and rewrites the word address of every request on its way down. It rewrites any address that comes back on the response channel with the exact opposite mapping, so the requester always sees its own address space. Three mappings are available, chosen by a static mode input: add a constant, rotate the word-select bits, or flip a chosen set of bits. A fourth mode code passes the address through untouched. A direction input selects whether the request path applies the forward or the reverse mapping. One design can therefore open a remapped region on entry and close it on exit, so remapped regions can be nested inside address-routed sub-systems.

Addresses are 30-bit word addresses over a 32-bit byte space with 4-byte words. The two byte-select bits are not carried, so no mapping can touch them. Write data (32 bits), the 4-bit byte enable and the write flag pass through unchanged. The request channel is valid/ready on both sides. A request moves on an edge where valid and ready are both high. The stage holds one request in an output register. It accepts a new one whenever that register is empty or is being drained in the same cycle, so a stall downstream propagates upstream in the same cycle. A held request stays stable until it is taken. The response channel carries valid, address and read data, and has no back-pressure.

Top module: `addr_xform_stage`

## Requirements
- R1: After reset the downstream request valid is low and the upstream ready is high.
- R2: A request accepted upstream on one clock edge is presented downstream from the next edge on, so the request path adds exactly one cycle.
- R3: Upstream ready equals (downstream valid low) or (downstream ready high); while downstream valid is high and downstream ready is low, every downstream request field holds its value.
- R4: Write flag, write data and byte enable reach the downstream side unchanged, and read data reaches the upstream side unchanged in the same cycle as its valid.
- R5: Mode code 2'b00 adds the 30-bit parameter to the address modulo 2^30; the reverse direction subtracts it modulo 2^30.
- R6: Mode code 2'b01 rotates the 30-bit address left by parameter bits [4:0] taken modulo 30 (so 0 and 30 give the identity and 31 acts as 1); the reverse direction rotates right by the same amount.
- R7: Mode code 2'b10 inverts exactly those address bits set in the 30-bit parameter, in both directions.
- R8: Mode code 2'b11 passes addresses through unchanged in both directions.
- R9: The response address leaves the stage in the same cycle it arrives, mapped with the direction opposite to the request path, so a response echoing a downstream request address returns the original upstream address.
- R10: With the direction input low the request path applies the forward mapping; with it high the request path applies the reverse mapping and the response path the forward one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Mapping select: 00 add, 01 rotate, 10 bit flip, 11 pass |
| cfg_reverse | input | 1 | 0: request path forward; 1: request path reverse |
| cfg_param | input | 30 | Offset, flip mask, or rotate amount in bits [4:0] |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_addr | input | 30 | Upstream word address |
| up_req_we | input | 1 | Write flag |
| up_req_wdata | input | 32 | Write data |
| up_req_be | input | 4 | Byte enable |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_addr | output | 30 | Mapped word address |
| dn_req_we | output | 1 | Write flag |
| dn_req_wdata | output | 32 | Write data |
| dn_req_be | output | 4 | Byte enable |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_addr | input | 30 | Downstream response word address |
| dn_rsp_rdata | input | 32 | Downstream read data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_addr | output | 30 | Response address mapped back |
| up_rsp_rdata | output | 32 | Read data |

## Verification
The hardest condition to reach from the ports is a full round trip under back-pressure. A request has to be parked in the output register, mapped one way, and later come back as a response that the opposite mapping restores, all while the configuration stays constant. The bench models the downstream side as a memory that echoes the presented address in the same cycle. It toggles downstream ready at random so requests stall and drain at mixed rates. It changes mode, direction and parameter only after draining the stage. Directed response-path probes cover the wrap of the add mode and the rotate amounts 0, 1, 30 and 31.

// File: rtl/addr_xform_pkg.sv
package addr_xform_pkg;
  localparam int unsigned WORD_AW = 30;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned ROT_W   = $clog2(WORD_AW);
  localparam int unsigned REQ_W   = WORD_AW + 1 + DATA_W + BE_W;

  typedef enum logic [1:0] {
    XF_ADD  = 2'b00,
    XF_ROT  = 2'b01,
    XF_FLIP = 2'b10,
    XF_PASS = 2'b11
  } xf_mode_e;

  typedef struct packed {
    logic [WORD_AW-1:0] addr;
    logic               we;
    logic [DATA_W-1:0]  data;
    logic [BE_W-1:0]    be;
  } xf_req_t;
endpackage

// File: rtl/addr_xform_rot.sv
module addr_xform_rot #(
  parameter int unsigned W  = 30,
  parameter int unsigned RW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [RW-1:0] amt_i,
  input  logic          right_i,
  output logic [W-1:0]  a_o
);
  localparam logic [RW-1:0] WRAP = RW'(W);

  logic [RW-1:0]  n;
  logic [2*W-1:0] dbl, shl, shr;

  always_comb begin
    n   = (amt_i >= WRAP) ? amt_i - WRAP : amt_i;
    dbl = {a_i, a_i};
    shl = dbl << n;
    shr = dbl >> n;
    a_o = right_i ? shr[W-1:0] : shl[2*W-1:W];
  end
endmodule

// File: rtl/addr_xform_unit.sv
module addr_xform_unit
  import addr_xform_pkg::*;
#(
  parameter int unsigned W  = WORD_AW,
  parameter int unsigned RW = $clog2(W)
) (
  input  xf_mode_e     mode_i,
  input  logic         reverse_i,
  input  logic [W-1:0] param_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] rot_out;

  addr_xform_rot #(.W(W), .RW(RW)) u_rot (
    .a_i    (addr_i),
    .amt_i  (param_i[RW-1:0]),
    .right_i(reverse_i),
    .a_o    (rot_out)
  );

  always_comb begin
    unique case (mode_i)
      XF_ADD:  addr_o = reverse_i ? (addr_i - param_i) : (addr_i + param_i);
      XF_ROT:  addr_o = rot_out;
      XF_FLIP: addr_o = addr_i ^ param_i;
      default: addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/addr_req_slice.sv
module addr_req_slice #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          full_q;
  logic [PW-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) data_q <= in_data;
  end
endmodule

// File: rtl/addr_xform_stage.sv
module addr_xform_stage
  import addr_xform_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_reverse,
  input  logic [WORD_AW-1:0]  cfg_param,
  input  logic                up_req_valid,
  output logic                up_req_ready,
  input  logic [WORD_AW-1:0]  up_req_addr,
  input  logic                up_req_we,
  input  logic [DATA_W-1:0]   up_req_wdata,
  input  logic [BE_W-1:0]     up_req_be,
  output logic                dn_req_valid,
  input  logic                dn_req_ready,
  output logic [WORD_AW-1:0]  dn_req_addr,
  output logic                dn_req_we,
  output logic [DATA_W-1:0]   dn_req_wdata,
  output logic [BE_W-1:0]     dn_req_be,
  input  logic                dn_rsp_valid,
  input  logic [WORD_AW-1:0]  dn_rsp_addr,
  input  logic [DATA_W-1:0]   dn_rsp_rdata,
  output logic                up_rsp_valid,
  output logic [WORD_AW-1:0]  up_rsp_addr,
  output logic [DATA_W-1:0]   up_rsp_rdata
);
  xf_mode_e           mode;
  logic [WORD_AW-1:0] req_mapped;
  xf_req_t            slice_in, slice_out;

  assign mode = xf_mode_e'(cfg_mode);

  // request path: direction as configured
  addr_xform_unit #(.W(WORD_AW)) u_req_xf (
    .mode_i   (mode),
    .reverse_i(cfg_reverse),
    .param_i  (cfg_param),
    .addr_i   (up_req_addr),
    .addr_o   (req_mapped)
  );

  // response path: opposite direction
  addr_xform_unit #(.W(WORD_AW)) u_rsp_xf (
    .mode_i   (mode),
    .reverse_i(!cfg_reverse),
    .param_i  (cfg_param),
    .addr_i   (dn_rsp_addr),
    .addr_o   (up_rsp_addr)
  );

  always_comb begin
    slice_in.addr = req_mapped;
    slice_in.we   = up_req_we;
    slice_in.data = up_req_wdata;
    slice_in.be   = up_req_be;
  end

  addr_req_slice #(.PW(REQ_W)) u_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (up_req_valid),
    .in_ready (up_req_ready),
    .in_data  (slice_in),
    .out_valid(dn_req_valid),
    .out_ready(dn_req_ready),
    .out_data (slice_out)
  );

  assign dn_req_addr  = slice_out.addr;
  assign dn_req_we    = slice_out.we;
  assign dn_req_wdata = slice_out.data;
  assign dn_req_be    = slice_out.be;

  assign up_rsp_valid = dn_rsp_valid;
  assign up_rsp_rdata = dn_rsp_rdata;
endmodule

// File: rtl/addr_xform_stage_chk.sv
module addr_xform_stage_chk
  import addr_xform_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cfg_mode,
  input logic [WORD_AW-1:0]  cfg_param,
  input logic                up_req_valid,
  input logic                up_req_ready,
  input logic [WORD_AW-1:0]  up_req_addr,
  input logic                up_req_we,
  input logic [DATA_W-1:0]   up_req_wdata,
  input logic [BE_W-1:0]     up_req_be,
  input logic                dn_req_valid,
  input logic                dn_req_ready,
  input logic [WORD_AW-1:0]  dn_req_addr,
  input logic                dn_req_we,
  input logic [DATA_W-1:0]   dn_req_wdata,
  input logic [BE_W-1:0]     dn_req_be,
  input logic                dn_rsp_valid,
  input logic [WORD_AW-1:0]  dn_rsp_addr,
  input logic [DATA_W-1:0]   dn_rsp_rdata,
  input logic                up_rsp_valid,
  input logic [WORD_AW-1:0]  up_rsp_addr,
  input logic [DATA_W-1:0]   up_rsp_rdata
);
  // R2
  accept_presents_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_valid && up_req_ready |=> dn_req_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr)
      && $stable(dn_req_wdata) && $stable(dn_req_be) && $stable(dn_req_we));

  // R3
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_req_valid |-> up_req_ready);

  // R4
  payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_valid && up_req_ready |=> dn_req_wdata == $past(up_req_wdata)
      && dn_req_be == $past(up_req_be) && dn_req_we == $past(up_req_we));

  // R4
  rsp_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid == dn_rsp_valid && (!dn_rsp_valid || up_rsp_rdata == dn_rsp_rdata));

  // R7
  flip_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_valid && up_req_ready && cfg_mode == 2'b10
      |=> dn_req_addr == ($past(up_req_addr) ^ $past(cfg_param)));

  // R7
  flip_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_valid && cfg_mode == 2'b10 |-> up_rsp_addr == (dn_rsp_addr ^ cfg_param));

  // R8
  pass_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_valid && cfg_mode == 2'b11 |-> up_rsp_addr == dn_rsp_addr);
endmodule

bind addr_xform_stage addr_xform_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_param(cfg_param),
  .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
  .up_req_addr(up_req_addr), .up_req_we(up_req_we),
  .up_req_wdata(up_req_wdata), .up_req_be(up_req_be),
  .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
  .dn_req_addr(dn_req_addr), .dn_req_we(dn_req_we),
  .dn_req_wdata(dn_req_wdata), .dn_req_be(dn_req_be),
  .dn_rsp_valid(dn_rsp_valid), .dn_rsp_addr(dn_rsp_addr),
  .dn_rsp_rdata(dn_rsp_rdata), .up_rsp_valid(up_rsp_valid),
  .up_rsp_addr(up_rsp_addr), .up_rsp_rdata(up_rsp_rdata)
);

// File: tb/addr_xform_stage_tb.sv
module addr_xform_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_reverse = 1'b0;
  logic [29:0] cfg_param = '0;
  logic        up_req_valid = 1'b0;
  logic        up_req_ready;
  logic [29:0] up_req_addr = '0;
  logic        up_req_we = 1'b0;
  logic [31:0] up_req_wdata = '0;
  logic [3:0]  up_req_be = '0;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic [29:0] dn_req_addr;
  logic        dn_req_we;
  logic [31:0] dn_req_wdata;
  logic [3:0]  dn_req_be;
  logic        dn_rsp_valid = 1'b0;
  logic [29:0] dn_rsp_addr = '0;
  logic [31:0] dn_rsp_rdata = '0;
  logic        up_rsp_valid;
  logic [29:0] up_rsp_addr;
  logic [31:0] up_rsp_rdata;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  addr_xform_stage u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference mapping
  function automatic logic [29:0] ref_map(input logic [29:0] a, input logic [1:0] m,
                                          input bit rev, input logic [29:0] p);
    logic [29:0] r;
    longint s;
    int n;
    r = a;
    case (m)
      2'b00: begin
        s = rev ? (longint'(a) - longint'(p) + 64'h4000_0000) : (longint'(a) + longint'(p));
        r = 30'(s % 64'h4000_0000);
      end
      2'b01: begin
        n = int'(p[4:0]) % 30;
        for (int i = 0; i < n; i++)
          r = rev ? {r[0], r[29:1]} : {r[28:0], r[29]};
      end
      2'b10: r = a ^ p;
      default: r = a;
    endcase
    return r;
  endfunction

  task automatic probe_rsp(input logic [1:0] m, input bit rev, input logic [29:0] p,
                           input logic [29:0] a, input logic [29:0] exp, input string req);
    cfg_mode = m; cfg_reverse = rev; cfg_param = p;
    dn_rsp_valid = 1'b1; dn_rsp_addr = a; dn_rsp_rdata = 32'hA5A5_0000 | 32'(a[15:0]);
    #1;
    chk(up_rsp_addr == exp, req, 64'(up_rsp_addr), 64'(exp));
    chk(up_rsp_valid && up_rsp_rdata == dn_rsp_rdata, "R4 rsp data", 64'(up_rsp_rdata), 64'(dn_rsp_rdata));
    dn_rsp_valid = 1'b0;
  endtask

  // model state
  bit          m_full = 0;
  logic [29:0] m_addr, m_orig;
  logic        m_we;
  logic [31:0] m_data;
  logic [3:0]  m_be;

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit exp_ready;
    bit pend;
    int mode_ix;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(dn_req_valid == 1'b0, "R1 dn valid", 64'(dn_req_valid), 0);
    chk(up_req_ready == 1'b1, "R1 up ready", 64'(up_req_ready), 1);

    // directed response-path probes (rsp applies direction opposite to cfg_reverse)
    probe_rsp(2'b00, 1'b1, 30'd2, 30'h3FFF_FFFF, 30'h1, "R5 add wrap");
    probe_rsp(2'b00, 1'b0, 30'd5, 30'd3, 30'h3FFF_FFFE, "R5 R10 sub wrap");
    probe_rsp(2'b01, 1'b1, 30'd1, 30'h2000_0000, 30'h1, "R6 rotl 1");
    probe_rsp(2'b01, 1'b1, 30'd31, 30'h2000_0001, 30'h3, "R6 rot 31 as 1");
    probe_rsp(2'b01, 1'b1, 30'd30, 30'h1234_5678, 30'h1234_5678, "R6 rot 30 identity");
    probe_rsp(2'b01, 1'b1, 30'd0, 30'h0ABC_DEF1, 30'h0ABC_DEF1, "R6 rot 0 identity");
    probe_rsp(2'b01, 1'b0, 30'd1, 30'h1, 30'h2000_0000, "R6 R10 rotr 1");
    probe_rsp(2'b10, 1'b0, 30'h0F0F_0F0F, 30'h0, 30'h0F0F_0F0F, "R7 flip");
    probe_rsp(2'b11, 1'b1, 30'h3FFF_FFFF, 30'h1555_5555, 30'h1555_5555, "R8 pass");

    cfg_mode = 2'b00; cfg_reverse = 1'b0; cfg_param = 30'h3FFF_FFF0;
    pend = 0; mode_ix = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      // outputs after the last edge
      chk(dn_req_valid == m_full, "R2 dn valid", 64'(dn_req_valid), 64'(m_full));
      if (m_full) begin
        chk(dn_req_addr == m_addr, "R5 R6 R7 R8 R10 dn addr", 64'(dn_req_addr), 64'(m_addr));
        chk(dn_req_wdata == m_data && dn_req_be == m_be && dn_req_we == m_we,
            "R3 R4 dn payload", {dn_req_we, dn_req_be, dn_req_wdata}, {m_we, m_be, m_data});
      end
      if (cyc % 150 == 149) pend = 1;
      if (pend && !m_full) begin
        mode_ix++;
        cfg_mode = 2'(mode_ix);
        cfg_reverse = $urandom_range(0, 1) != 0;
        cfg_param = 30'($urandom);
        if (mode_ix % 3 == 0) cfg_param = {25'h0, 5'($urandom_range(28, 31))};
        pend = 0;
      end
      // echo memory: response carries the presented address
      dn_rsp_valid = dn_req_valid;
      dn_rsp_addr  = dn_req_addr;
      dn_rsp_rdata = ~dn_req_wdata;
      up_req_valid = !pend && ($urandom_range(0, 3) != 0);
      up_req_addr  = 30'($urandom);
      up_req_we    = $urandom_range(0, 1) != 0;
      up_req_wdata = $urandom;
      up_req_be    = 4'($urandom);
      dn_req_ready = $urandom_range(0, 2) != 0;
      #1;
      exp_ready = !m_full || dn_req_ready;
      chk(up_req_ready == exp_ready, "R3 up ready", 64'(up_req_ready), 64'(exp_ready));
      if (m_full) begin
        chk(up_rsp_valid && up_rsp_addr == m_orig, "R9 round trip addr", 64'(up_rsp_addr), 64'(m_orig));
        chk(up_rsp_rdata == ~m_data, "R4 rsp rdata", 64'(up_rsp_rdata), 64'(~m_data));
      end
      // advance model to the next edge
      if (m_full && dn_req_ready) m_full = 0;
      if (up_req_valid && exp_ready) begin
        m_full = 1;
        m_orig = up_req_addr;
        m_addr = ref_map(up_req_addr, cfg_mode, cfg_reverse, cfg_param);
        m_we = up_req_we; m_data = up_req_wdata; m_be = up_req_be;
      end
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule